// File: doc/BRIEF.md
# PIPE PHY Command Sequencer

This block sits on the MAC side of a PIPE-style link between a USB 3 link layer and its PHY. It accepts one request at a time from the link state machine: either a receiver-detection probe or a change of the PHY power state. It drives the power-state and detect/loopback outputs toward the PHY and waits for the PHY's PhyStatus handshake. When the handshake arrives, it returns a one-cycle completion strobe and, after a detection, the receiver-present result.

A move from P0 into a low-power state is not issued at once. The request first spends a programmable settling delay, then a second, shorter internal delay, and only then changes the power-state output and waits for PhyStatus. A request back to P0 goes straight to the wait. A wait that sees no PhyStatus within a programmable number of cycles ends with a sticky timeout flag. The current command state is visible on a 3-bit read-only debug port. Any state code outside the defined set falls back to idle.

Top module: `pipe_cmd_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `cmd_state` is 3'b000, `powerdown` is 2'b10 (P2), and `tx_det_lb`, `done`, `rx_present` and `timeout` are all 0.
- R2: `cmd_state` only ever shows these codes: 3'b000 idle, 3'b001 detect request, 3'b010 detect wait, 3'b011 power settle delay, 3'b100 internal delay, 3'b101 power wait. Codes 3'b110 and 3'b111 never appear.
- R3: A request is accepted only on a cycle in which `cmd_state` is idle. If `req_det` and `req_pwr` are both high in that cycle, detection wins and the power request is dropped. Requests raised while the block is busy have no effect.
- R4: An accepted detection shows 3'b001 for exactly one cycle and then 3'b010. `tx_det_lb` is 1 in both states.
- R5: A `phy_status` pulse in 3'b010 returns the block to idle on the next cycle. At the same time `rx_present` is updated to 1 if `rx_status` was 3'b011 and to 0 otherwise. It then holds that value until the next detection completes.
- R6: A power request to P1, P2 or P3 (`pwr_tgt` 2'b01, 2'b10, 2'b11) runs through the states in this order: 3'b011 for PWR_DLY_CYC cycles, then 3'b100 for INT_DLY_CYC cycles, then 3'b101. `powerdown` keeps its old value until 3'b101 is entered and takes the target value on that same cycle.
- R7: A power request to P0 (`pwr_tgt` 2'b00) skips both delays. It enters 3'b101 on the cycle after acceptance, with `powerdown` already 2'b00.
- R8: A `phy_status` pulse in either wait state (3'b010 or 3'b101) makes `done` high for exactly one cycle, on the same cycle that `cmd_state` returns to idle. `done` is low at all other times.
- R9: A wait state that sees no `phy_status` for TMO_CYC cycles returns to idle and sets `timeout`, without a `done` strobe. `timeout` stays set across later commands until `tmo_clr` is pulsed, and it reads 0 on the following cycle.
- R10: `tx_det_lb` is 0 in every state other than 3'b001 and 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PIPE-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_det | input | 1 | Request a receiver-detection probe |
| req_pwr | input | 1 | Request a power-state change |
| pwr_tgt | input | 2 | Target power state for `req_pwr` (0=P0 .. 3=P3) |
| phy_status | input | 1 | PhyStatus handshake pulse from the PHY |
| rx_status | input | 3 | PHY receive status, sampled together with `phy_status` during detection |
| tmo_clr | input | 1 | Clears the sticky timeout flag |
| powerdown | output | 2 | Power-state output to the PHY |
| tx_det_lb | output | 1 | Detect-receiver/loopback output to the PHY |
| done | output | 1 | One-cycle completion strobe |
| rx_present | output | 1 | Result of the last completed detection |
| timeout | output | 1 | Sticky flag: a PhyStatus wait expired |
| cmd_state | output | 3 | Read-only debug view of the command state |

## Verification
The assertions assume that `phy_status` and `rx_status` are synchronous to `clk`. They also assume that the PHY raises `phy_status` only as a single-cycle pulse while a wait state is active. Under that assumption, every `done` strobe can be traced to a PhyStatus seen in the previous cycle, and every rise of `timeout` to a wait that saw none. The stimulus changes inputs only between clock edges. It raises `phy_status` for exactly one cycle, and only after `cmd_state` shows a wait code. In the timeout cases it leaves `phy_status` low for the whole wait.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;

  typedef enum logic [2:0] {
    CS_IDLE     = 3'b000,
    CS_DET_REQ  = 3'b001,
    CS_DET_WAIT = 3'b010,
    CS_PWR_DLY  = 3'b011,
    CS_PWR_INT  = 3'b100,
    CS_PWR_WAIT = 3'b101
  } cmd_state_e;

  localparam logic [1:0] PD_P0 = 2'b00;
  localparam logic [1:0] PD_P2 = 2'b10;
  localparam logic [2:0] RXST_PRESENT = 3'b011;

endpackage

// File: rtl/pipe_seq_rst_sync.sv
module pipe_seq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pipe_seq_arb.sv
module pipe_seq_arb
  import pipe_seq_pkg::*;
(
  input  logic       idle,
  input  logic       req_det,
  input  logic       req_pwr,
  input  logic [1:0] pwr_tgt,
  output logic       go_det,
  output logic       go_pwr,
  output logic       go_p0
);
  // Detection has priority over a power change in the same idle cycle.
  always_comb begin
    go_det = idle & req_det;
    go_pwr = idle & req_pwr & ~req_det;
    go_p0  = go_pwr & (pwr_tgt == PD_P0);
  end
endmodule

// File: rtl/pipe_seq_timer.sv
module pipe_seq_timer #(
  parameter int PWR_DLY_CYC = 4,
  parameter int INT_DLY_CYC = 2,
  parameter int TMO_CYC     = 1024,
  parameter int CNT_W       = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic dly1_end,
  output logic dly2_end,
  output logic tmo_end
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)              cnt_d = '0;
    else if (cnt_q == CNT_SAT) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dly1_end = (cnt_q == CNT_W'(PWR_DLY_CYC - 1));
  assign dly2_end = (cnt_q == CNT_W'(INT_DLY_CYC - 1));
  assign tmo_end  = (cnt_q == CNT_W'(TMO_CYC - 1));
endmodule

// File: rtl/pipe_seq_fsm.sv
module pipe_seq_fsm
  import pipe_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_det,
  input  logic       go_pwr,
  input  logic       go_p0,
  input  logic [1:0] pwr_tgt,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  input  logic       tmo_clr,
  input  logic       dly1_end,
  input  logic       dly2_end,
  input  logic       tmo_end,
  output logic [2:0] state,
  output logic       restart,
  output logic [1:0] powerdown,
  output logic       done,
  output logic       rx_present,
  output logic       timeout
);
  cmd_state_e st_q, st_d;
  logic [1:0] tgt_q;
  logic       in_wait, pd_load, tgt_en, det_fin, tmo_hit;
  logic [1:0] pd_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      CS_IDLE: begin
        if (go_det)      st_d = CS_DET_REQ;
        else if (go_p0)  st_d = CS_PWR_WAIT;
        else if (go_pwr) st_d = CS_PWR_DLY;
      end
      CS_DET_REQ:  st_d = CS_DET_WAIT;
      CS_DET_WAIT: if (phy_status || tmo_end) st_d = CS_IDLE;
      CS_PWR_DLY:  if (dly1_end) st_d = CS_PWR_INT;
      CS_PWR_INT:  if (dly2_end) st_d = CS_PWR_WAIT;
      CS_PWR_WAIT: if (phy_status || tmo_end) st_d = CS_IDLE;
      default:     st_d = CS_IDLE;
    endcase
  end

  always_comb begin
    in_wait = (st_q == CS_DET_WAIT) || (st_q == CS_PWR_WAIT);
    restart = (st_d != st_q);
    tgt_en  = go_pwr && (st_q == CS_IDLE);
    pd_load = (st_q != CS_PWR_WAIT) && (st_d == CS_PWR_WAIT);
    pd_d    = (st_q == CS_IDLE) ? pwr_tgt : tgt_q;
    det_fin = (st_q == CS_DET_WAIT) && phy_status;
    tmo_hit = in_wait && !phy_status && tmo_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= CS_IDLE;
      tgt_q      <= PD_P2;
      powerdown  <= PD_P2;
      done       <= 1'b0;
      rx_present <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= in_wait && phy_status;
      if (tgt_en)  tgt_q      <= pwr_tgt;
      if (pd_load) powerdown  <= pd_d;
      if (det_fin) rx_present <= (rx_status == RXST_PRESENT);
      if (tmo_hit)      timeout <= 1'b1;
      else if (tmo_clr) timeout <= 1'b0;
    end
  end

  assign state = st_q;

  // The delay states are left only when the timer signals the end of the window.
  assert_dly_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_PWR_DLY && !dly1_end) |=> (st_q == CS_PWR_DLY));
  assert_int_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_PWR_INT && !dly2_end) |=> (st_q == CS_PWR_INT));
  // Arbiter never grants both request kinds at once.
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_det && go_pwr));
endmodule

// File: rtl/pipe_cmd_seq.sv
module pipe_cmd_seq
  import pipe_seq_pkg::*;
#(
  parameter int PWR_DLY_CYC = 4,
  parameter int INT_DLY_CYC = 2,
  parameter int TMO_CYC     = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_det,
  input  logic       req_pwr,
  input  logic [1:0] pwr_tgt,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  input  logic       tmo_clr,
  output logic [1:0] powerdown,
  output logic       tx_det_lb,
  output logic       done,
  output logic       rx_present,
  output logic       timeout,
  output logic [2:0] cmd_state
);
  localparam int MAX_A = (PWR_DLY_CYC > INT_DLY_CYC) ? PWR_DLY_CYC : INT_DLY_CYC;
  localparam int MAX_C = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic rst_int_n;
  logic go_det, go_pwr, go_p0;
  logic restart, dly1_end, dly2_end, tmo_end;

  pipe_seq_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_int_n)
  );

  pipe_seq_arb u_arb (
    .idle(cmd_state == CS_IDLE), .req_det(req_det), .req_pwr(req_pwr),
    .pwr_tgt(pwr_tgt), .go_det(go_det), .go_pwr(go_pwr), .go_p0(go_p0)
  );

  pipe_seq_timer #(
    .PWR_DLY_CYC(PWR_DLY_CYC), .INT_DLY_CYC(INT_DLY_CYC),
    .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .restart(restart),
    .dly1_end(dly1_end), .dly2_end(dly2_end), .tmo_end(tmo_end)
  );

  pipe_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .go_det(go_det), .go_pwr(go_pwr),
    .go_p0(go_p0), .pwr_tgt(pwr_tgt), .phy_status(phy_status),
    .rx_status(rx_status), .tmo_clr(tmo_clr), .dly1_end(dly1_end),
    .dly2_end(dly2_end), .tmo_end(tmo_end), .state(cmd_state),
    .restart(restart), .powerdown(powerdown), .done(done),
    .rx_present(rx_present), .timeout(timeout)
  );

  assign tx_det_lb = (cmd_state == CS_DET_REQ) || (cmd_state == CS_DET_WAIT);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_state inside {CS_IDLE, CS_DET_REQ, CS_DET_WAIT, CS_PWR_DLY, CS_PWR_INT, CS_PWR_WAIT});
  assert_det_step_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_state == CS_DET_REQ) |=> (cmd_state == CS_DET_WAIT));
  assert_pd_change_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(powerdown) |-> (cmd_state == CS_PWR_WAIT && $past(cmd_state) != CS_PWR_WAIT));
  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> ($past(phy_status) &&
              ($past(cmd_state) == CS_DET_WAIT || $past(cmd_state) == CS_PWR_WAIT) &&
              cmd_state == CS_IDLE));
  assert_tmo_cause_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(timeout) |-> (!$past(phy_status) && !done &&
              ($past(cmd_state) == CS_DET_WAIT || $past(cmd_state) == CS_PWR_WAIT)));
  assert_txdet_gate_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_state != CS_DET_REQ && cmd_state != CS_DET_WAIT) |-> !tx_det_lb);
endmodule

// File: tb/tb_pipe_cmd_seq.sv
`timescale 1ns/1ps
module tb_pipe_cmd_seq;
  localparam int PWR_D = 4;
  localparam int INT_D = 2;
  localparam int TMO   = 20;

  logic clk = 1'b0;
  logic rst_n, req_det, req_pwr, phy_status, tmo_clr;
  logic [1:0] pwr_tgt;
  logic [2:0] rx_status;
  logic [1:0] powerdown;
  logic tx_det_lb, done, rx_present, timeout;
  logic [2:0] cmd_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] pd_model;

  always #4 clk = ~clk;

  pipe_cmd_seq #(.PWR_DLY_CYC(PWR_D), .INT_DLY_CYC(INT_D), .TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .req_det(req_det), .req_pwr(req_pwr),
    .pwr_tgt(pwr_tgt), .phy_status(phy_status), .rx_status(rx_status),
    .tmo_clr(tmo_clr), .powerdown(powerdown), .tx_det_lb(tx_det_lb),
    .done(done), .rx_present(rx_present), .timeout(timeout), .cmd_state(cmd_state)
  );

  // vector: {kind(1=power), target[1:0], rx_status[2:0], latency[3:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 2'd0, 3'b011, 4'd3},
    {1'b0, 2'd0, 3'b000, 4'd0},
    {1'b1, 2'd1, 3'b000, 4'd2},
    {1'b1, 2'd0, 3'b000, 4'd1},
    {1'b1, 2'd3, 3'b000, 4'd5},
    {1'b0, 2'd0, 3'b011, 4'd1},
    {1'b1, 2'd2, 3'b000, 4'd0},
    {1'b1, 2'd0, 3'b000, 4'd4}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_phy(input logic [2:0] rx);
    phy_status = 1'b1; rx_status = rx;
    @(negedge clk);
    phy_status = 1'b0; rx_status = 3'b000;
  endtask

  task automatic run_det(input logic [2:0] rx, input int lat);
    req_det = 1'b1;
    @(negedge clk); req_det = 1'b0;
    check(cmd_state == 3'b001, "R4 detect request code", cmd_state, 1);
    check(tx_det_lb == 1'b1, "R4 tx_det_lb in request", tx_det_lb, 1);
    @(negedge clk);
    check(cmd_state == 3'b010, "R4 detect wait code", cmd_state, 2);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(cmd_state == 3'b010 && tx_det_lb, "R4 wait held", cmd_state, 2);
    end
    pulse_phy(rx);
    check(done == 1'b1, "R8 done after detect", done, 1);
    check(cmd_state == 3'b000, "R5 idle after detect", cmd_state, 0);
    check(rx_present == (rx == 3'b011), "R5 receiver result", rx_present, int'(rx == 3'b011));
    check(tx_det_lb == 1'b0, "R10 tx_det_lb in idle", tx_det_lb, 0);
    check(powerdown == pd_model, "R6 powerdown untouched by detect", powerdown, pd_model);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  task automatic run_pwr(input logic [1:0] tgt, input int lat, input bit finish);
    int n1, n2;
    req_pwr = 1'b1; pwr_tgt = tgt;
    @(negedge clk); req_pwr = 1'b0; pwr_tgt = 2'd0;
    if (tgt != 2'd0) begin
      n1 = 0; n2 = 0;
      while (cmd_state == 3'b011 && n1 < 50) begin
        n1++;
        check(powerdown == pd_model && !tx_det_lb, "R6 no change during settle", powerdown, pd_model);
        @(negedge clk);
      end
      while (cmd_state == 3'b100 && n2 < 50) begin
        n2++;
        check(powerdown == pd_model, "R6 no change during internal delay", powerdown, pd_model);
        @(negedge clk);
      end
      check(n1 == PWR_D, "R6 settle cycles", n1, PWR_D);
      check(n2 == INT_D, "R6 internal cycles", n2, INT_D);
    end else begin
      check(cmd_state == 3'b101, "R7 P0 straight to wait", cmd_state, 5);
    end
    pd_model = tgt;
    check(cmd_state == 3'b101, "R6 power wait code", cmd_state, 5);
    check(powerdown == tgt, "R6 powerdown on wait entry", powerdown, tgt);
    if (finish) begin
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(cmd_state == 3'b101, "R8 wait held", cmd_state, 5);
      end
      pulse_phy(3'b000);
      check(done == 1'b1 && cmd_state == 3'b000, "R8 done and idle after power", done, 1);
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, seen_bad;
    rst_n = 1'b0; req_det = 0; req_pwr = 0; pwr_tgt = 0;
    phy_status = 0; rx_status = 0; tmo_clr = 0;
    pd_model = 2'b10;
    repeat (3) @(negedge clk);
    check(cmd_state == 3'b000 && powerdown == 2'b10, "R1 reset state/powerdown", powerdown, 2);
    check(!tx_det_lb && !done && !rx_present && !timeout, "R1 reset outputs", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_state == 3'b000 && powerdown == 2'b10 && !timeout, "R1 after release", cmd_state, 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][9]) run_pwr(VEC[v][8:7], int'(VEC[v][3:0]), 1'b1);
      else           run_det(VEC[v][6:4], int'(VEC[v][3:0]));
      @(negedge clk);
    end

    // R3 priority: both requests in one idle cycle
    req_det = 1'b1; req_pwr = 1'b1; pwr_tgt = 2'd3;
    @(negedge clk); req_det = 0; req_pwr = 0; pwr_tgt = 0;
    check(cmd_state == 3'b001, "R3 detect wins", cmd_state, 1);
    @(negedge clk); pulse_phy(3'b000);
    check(powerdown == pd_model, "R3 dropped power request", powerdown, pd_model);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(cmd_state == 3'b000, "R3 no deferred power request", cmd_state, 0);

    // R3 ignored while busy
    req_pwr = 1'b1; pwr_tgt = 2'd1;
    @(negedge clk); req_pwr = 0;
    req_det = 1'b1; req_pwr = 1'b1; pwr_tgt = 2'd3;
    @(negedge clk); req_det = 0; req_pwr = 0; pwr_tgt = 0;
    seen_bad = 0; n = 0;
    while (cmd_state != 3'b101 && n < 50) begin
      if (cmd_state == 3'b001) seen_bad = 1;
      n++; @(negedge clk);
    end
    pd_model = 2'd1;
    check(powerdown == 2'd1, "R3 busy request did not change target", powerdown, 1);
    pulse_phy(3'b000);
    repeat (3) begin
      @(negedge clk);
      if (cmd_state != 3'b000) seen_bad = 1;
    end
    check(seen_bad == 0, "R3 busy requests had no effect", seen_bad, 0);

    // R9 detect timeout
    req_det = 1'b1;
    @(negedge clk); req_det = 0;
    @(negedge clk);
    n = 0; seen_bad = 0;
    while (cmd_state == 3'b010 && n < 100) begin
      if (done) seen_bad = 1;
      n++; @(negedge clk);
    end
    check(n == TMO, "R9 detect wait length", n, TMO);
    check(cmd_state == 3'b000 && timeout == 1'b1, "R9 timeout set", timeout, 1);
    check(done == 1'b0 && seen_bad == 0, "R9 no done on timeout", done, 0);
    // sticky across a good command
    run_det(3'b011, 0);
    check(timeout == 1'b1, "R9 timeout sticky", timeout, 1);
    tmo_clr = 1'b1;
    @(negedge clk); tmo_clr = 0;
    check(timeout == 1'b0, "R9 timeout cleared", timeout, 0);

    // R9 power timeout keeps the new powerdown
    run_pwr(2'd2, 0, 1'b0);
    n = 0;
    while (cmd_state == 3'b101 && n < 100) begin n++; @(negedge clk); end
    check(n == TMO, "R9 power wait length", n, TMO);
    check(timeout == 1'b1 && !done && powerdown == 2'd2, "R9 power timeout", timeout, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule